// File: doc/BRIEF.md
# Decimating FIR Coefficient Address Sequencer

This block drives the address side of a decimating FIR filter whose coefficients and input samples sit in RAM. It counts incoming samples, picks out the sample on which a new output computation begins, and then walks the taps at one per clock. For each tap it gives a coefficient-memory address and a data-memory read index. It flags the first and last tap, and it pulses an output strobe one cycle after the last tap so the multiply-accumulate stage knows its sum is complete. The datapath and the memories are outside this block.

Four registers are written through a small select/data port: decimation minus one, decimation phase, tap count minus one, and coefficient base offset. The offset, the phase and the tap count are copied into working registers only when a computation launches. Software can therefore retarget the next output to another filter stored elsewhere in the 256-word coefficient space while the current output is still being computed. A resynchronization input restarts the sample counter and leaves the programmed registers as they are.

Top module: `fir_coef_seq`

## Requirements
- R1: After reset, tap_valid_o, start_o, last_o and out_strobe_o are low. All registers reset to 0, which means decimation 1, phase 0, one tap and offset 0.
- R2: wr_sel_i selects the register a write goes to: 0 is decimation minus one (M-1), 1 is phase, 2 is tap count minus one (N-1), 3 is coefficient offset. A counter steps once per sample_i and wraps to 0 after the sample on which it is at or above M-1. A sample that arrives while the counter equals the working phase triggers a computation. The working phase resets to 0.
- R3: A computation issues N taps on N consecutive clocks with tap_valid_o high. On tap k, coef_addr_o equals the working offset plus k, modulo 256.
- R4: start_o is high on tap 0 only. last_o is high on tap N-1 only. out_strobe_o is high exactly one cycle after last_o.
- R5: On tap k, data_idx_o equals the triggering sample's index minus k, modulo 256. A sample's index is the number of samples received before it since reset, modulo 256.
- R6: The offset register is copied to the working offset only at launch. Writing the offset during a computation leaves that computation's addresses unchanged, and the next computation uses the new value.
- R7: The phase register is copied to the working phase at each launch. A new phase therefore decides triggering only after the next launch.
- R8: A trigger that arrives while a computation is running is held. Its computation starts on the clock after the running one's last tap, with no idle cycle, and uses the index of the triggering sample.
- R9: A sync_i pulse clears the sample counter and any held trigger. It does not change the programmed phase or the working phase.
- R10: The tap count is copied at launch. Writing it during a computation does not change that computation's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register select (0 decim, 1 phase, 2 taps, 3 offset) |
| wr_data_i | input | 8 | Register write data |
| sample_i | input | 1 | Input sample strobe |
| sync_i | input | 1 | Resynchronize sample counter |
| tap_valid_o | output | 1 | A tap is being issued this cycle |
| start_o | output | 1 | First tap of a computation |
| last_o | output | 1 | Last tap of a computation |
| out_strobe_o | output | 1 | Computation finished, result ready |
| coef_addr_o | output | 8 | Coefficient memory address |
| data_idx_o | output | 8 | Data memory read index |

## Verification
A sample that triggers an immediate launch shows tap 0 one clock after the edge that samples it, and tap k shows k clocks after that. last_o appears N clocks after the triggering edge and out_strobe_o one clock later. A held trigger shifts the whole run to start one clock after the running computation's last tap. The bench's driver models the counter and the working registers at each sample, pushes the tap items each trigger should produce, and leaves all timing to a monitor. That monitor samples one nanosecond after every rising edge, pops one item per tap_valid_o cycle, and checks the out_strobe_o relation against the previous cycle's last_o. Gaps, extra taps and reordering are therefore caught without hard-coding cycle numbers in the stimulus.

// File: rtl/fir_seq_pkg.sv
package fir_seq_pkg;
  typedef enum logic [1:0] {
    SEL_DECIM  = 2'd0,
    SEL_PHASE  = 2'd1,
    SEL_NTAPS  = 2'd2,
    SEL_OFFSET = 2'd3
  } cfg_sel_e;

  localparam int unsigned NUM_REGS = 4;
endpackage

// File: rtl/fir_seq_cfg.sv
module fir_seq_cfg
  import fir_seq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [1:0]   wr_sel_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] decim_o,
  output logic [W-1:0] phase_o,
  output logic [W-1:0] ntaps_o,
  output logic [W-1:0] offset_o
);
  logic [W-1:0] reg_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 reg_q[i] <= '0;
      else if (wr_en_i && wr_sel_i == 2'(i))       reg_q[i] <= wr_data_i;
    end
  end

  assign decim_o  = reg_q[SEL_DECIM];
  assign phase_o  = reg_q[SEL_PHASE];
  assign ntaps_o  = reg_q[SEL_NTAPS];
  assign offset_o = reg_q[SEL_OFFSET];
endmodule

// File: rtl/fir_seq_trig.sv
module fir_seq_trig #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_i,
  input  logic          sync_i,
  input  logic [W-1:0]  decim_i,
  input  logic [W-1:0]  phase_act_i,
  input  logic          launch_i,
  output logic          req_o,
  output logic [IW-1:0] req_base_o
);
  logic [W-1:0]  cnt_q;
  logic [IW-1:0] wp_q;
  logic          pend_q;
  logic [IW-1:0] pend_base_q;
  logic          hit;

  assign hit        = sample_i && !sync_i && (cnt_q == phase_act_i);
  assign req_o      = hit || pend_q;
  assign req_base_o = pend_q ? pend_base_q : wp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (sync_i)   cnt_q <= '0;
    else if (sample_i) cnt_q <= (cnt_q >= decim_i) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wp_q <= '0;
    else if (sample_i) wp_q <= wp_q + 1'b1;
  end

  // held trigger: a hit during a run waits; a second hit while held merges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_base_q <= '0;
    end else if (sync_i) begin
      pend_q      <= 1'b0;
    end else if (pend_q) begin
      if (launch_i) begin
        pend_q      <= hit;
        pend_base_q <= wp_q;
      end
    end else if (hit && !launch_i) begin
      pend_q      <= 1'b1;
      pend_base_q <= wp_q;
    end
  end

  a_r9_sync_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (cnt_q == '0) && !pend_q);

  a_r2_hit_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !sync_i) |=> cnt_q != $past(cnt_q) || $past(cnt_q) == '0);
endmodule

// File: rtl/fir_seq_taps.sv
module fir_seq_taps #(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [IW-1:0] base_i,
  input  logic [W-1:0]  phase_i,
  input  logic [W-1:0]  ntaps_i,
  input  logic [W-1:0]  offset_i,
  output logic          launch_o,
  output logic [W-1:0]  phase_act_o,
  output logic          tap_valid_o,
  output logic          start_o,
  output logic          last_o,
  output logic          out_strobe_o,
  output logic [W-1:0]  coef_addr_o,
  output logic [IW-1:0] data_idx_o
);
  logic          busy_q;
  logic [W-1:0]  tap_q;
  logic [W-1:0]  off_q;
  logic [W-1:0]  nt_q;
  logic [W-1:0]  ph_q;
  logic [IW-1:0] base_q;
  logic          strobe_q;
  logic          at_last;

  assign at_last  = busy_q && (tap_q == nt_q);
  assign launch_o = req_i && (!busy_q || at_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tap_q  <= '0;
      off_q  <= '0;
      nt_q   <= '0;
      ph_q   <= '0;
      base_q <= '0;
    end else if (launch_o) begin
      busy_q <= 1'b1;
      tap_q  <= '0;
      off_q  <= offset_i;
      nt_q   <= ntaps_i;
      ph_q   <= phase_i;
      base_q <= base_i;
    end else if (at_last) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      tap_q  <= tap_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= at_last;
  end

  assign phase_act_o  = ph_q;
  assign tap_valid_o  = busy_q;
  assign start_o      = busy_q && (tap_q == '0);
  assign last_o       = at_last;
  assign out_strobe_o = strobe_q;
  assign coef_addr_o  = off_q + tap_q;
  assign data_idx_o   = base_q - IW'(tap_q);

  a_r4_strobe_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> out_strobe_o);

  a_r4_strobe_only_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_strobe_o |-> $past(last_o));

  a_r3_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_valid_o && !last_o) |=> coef_addr_o == $past(coef_addr_o) + 1'b1);

  a_r5_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_valid_o && !last_o) |=> data_idx_o == $past(data_idx_o) - 1'b1);

  a_r8_no_midrun_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(!tap_valid_o || last_o));
endmodule

// File: rtl/fir_coef_seq.sv
module fir_coef_seq
  import fir_seq_pkg::*;
#(
  parameter int unsigned W  = 8,
  parameter int unsigned IW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_sel_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          sample_i,
  input  logic          sync_i,
  output logic          tap_valid_o,
  output logic          start_o,
  output logic          last_o,
  output logic          out_strobe_o,
  output logic [W-1:0]  coef_addr_o,
  output logic [IW-1:0] data_idx_o
);
  logic [W-1:0]  decim, phase, ntaps, offset, phase_act;
  logic          req, launch;
  logic [IW-1:0] req_base;

  fir_seq_cfg #(.W(W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .decim_o   (decim),
    .phase_o   (phase),
    .ntaps_o   (ntaps),
    .offset_o  (offset)
  );

  fir_seq_trig #(.W(W), .IW(IW)) u_trig (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sample_i    (sample_i),
    .sync_i      (sync_i),
    .decim_i     (decim),
    .phase_act_i (phase_act),
    .launch_i    (launch),
    .req_o       (req),
    .req_base_o  (req_base)
  );

  fir_seq_taps #(.W(W), .IW(IW)) u_taps (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req),
    .base_i       (req_base),
    .phase_i      (phase),
    .ntaps_i      (ntaps),
    .offset_i     (offset),
    .launch_o     (launch),
    .phase_act_o  (phase_act),
    .tap_valid_o  (tap_valid_o),
    .start_o      (start_o),
    .last_o       (last_o),
    .out_strobe_o (out_strobe_o),
    .coef_addr_o  (coef_addr_o),
    .data_idx_o   (data_idx_o)
  );

  a_r1_flags_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tap_valid_o |-> !start_o && !last_o);
endmodule

// File: tb/fir_coef_seq_test.sv
module fir_coef_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       sample = 1'b0;
  logic       sync = 1'b0;
  logic       tap_valid, start, last, out_strobe;
  logic [7:0] coef_addr, data_idx;

  always #2 clk = ~clk;

  fir_coef_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .sample_i(sample), .sync_i(sync),
    .tap_valid_o(tap_valid), .start_o(start), .last_o(last),
    .out_strobe_o(out_strobe), .coef_addr_o(coef_addr), .data_idx_o(data_idx)
  );

  typedef struct {
    logic [7:0] addr;
    logic [7:0] idx;
    bit         first;
    bit         lst;
    string      tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  bit mon_en = 0;
  bit done = 0;

  // model of programmed and working state
  logic [7:0] m_dec = 0, m_ph = 0, m_nt = 0, m_off = 0, m_ph_act = 0, m_cnt = 0, m_wp = 0;
  string cur_tag = "R2";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      2'd0: m_dec = d;
      2'd1: m_ph  = d;
      2'd2: m_nt  = d;
      default: m_off = d;
    endcase
  endtask

  task automatic samp();
    @(negedge clk);
    sample = 1'b1;
    if (m_cnt == m_ph_act) begin
      for (int k = 0; k <= int'(m_nt); k++) begin
        item_t it;
        it.addr  = m_off + 8'(k);
        it.idx   = m_wp - 8'(k);
        it.first = (k == 0);
        it.lst   = (k == int'(m_nt));
        it.tag   = cur_tag;
        q.push_back(it);
      end
      m_ph_act = m_ph;
    end
    m_cnt = (m_cnt >= m_dec) ? 8'd0 : m_cnt + 8'd1;
    m_wp  = m_wp + 8'd1;
    @(negedge clk);
    sample = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk);
    sync = 1'b1;
    m_cnt = 0;
    @(negedge clk);
    sync = 1'b0;
  endtask

  // monitor: scoreboard pop per issued tap, strobe relation per cycle
  bit prev_last = 0;
  always @(posedge clk) begin
    #1;
    if (mon_en) begin
      if (out_strobe || prev_last)
        chk(out_strobe == prev_last, "R4", "out_strobe", out_strobe, prev_last);
      if (tap_valid) begin
        if (q.size() == 0) begin
          chk(0, cur_tag, "unexpected tap addr", coef_addr, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(coef_addr == it.addr, it.tag, "R3 coef_addr", coef_addr, it.addr);
          chk(data_idx == it.idx, it.tag, "R5 data_idx", data_idx, it.idx);
          chk(start == it.first, it.tag, "R4 start", start, it.first);
          chk(last == it.lst, it.tag, "R4 last", last, it.lst);
        end
      end else if (start || last) begin
        chk(0, "R4", "flag without tap", {start, last}, 0);
      end
      prev_last = last;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(posedge clk); #1;
    chk(!tap_valid && !start && !last && !out_strobe, "R1", "outputs in reset",
        {tap_valid, start, last, out_strobe}, 0);
    rst_n = 1'b1;
    idle(2);
    chk(!tap_valid && !start && !last && !out_strobe, "R1", "outputs after reset",
        {tap_valid, start, last, out_strobe}, 0);
    mon_en = 1;

    // R1 defaults: M=1, N=1, offset 0 -> every sample triggers
    cur_tag = "R1";
    samp(); idle(4); samp(); idle(6);

    // R2 decimation 4, 3 taps, offset 0x10
    cur_tag = "R2";
    wr(2'd0, 8'd3); wr(2'd2, 8'd2); wr(2'd3, 8'h10);
    for (int i = 0; i < 9; i++) begin samp(); idle(4); end
    idle(10);

    // R3 address wrap
    cur_tag = "R3";
    wr(2'd0, 8'd0); do_sync(); wr(2'd3, 8'hFE); wr(2'd2, 8'd3);
    samp(); idle(12);

    // R6 offset rewritten mid-run
    cur_tag = "R6";
    wr(2'd2, 8'd7); wr(2'd3, 8'h20);
    samp(); idle(1); wr(2'd3, 8'h40); idle(12);
    samp(); idle(14);

    // R10 tap count rewritten mid-run
    cur_tag = "R10";
    samp(); idle(1); wr(2'd2, 8'd2); idle(12);
    samp(); idle(10);

    // R7 phase takes effect after next launch
    cur_tag = "R7";
    wr(2'd0, 8'd3); do_sync(); wr(2'd1, 8'd2);
    for (int i = 0; i < 10; i++) begin samp(); idle(6); end
    idle(10);

    // R9 sync keeps phase, restarts counter
    cur_tag = "R9";
    samp(); idle(4); do_sync();
    for (int i = 0; i < 6; i++) begin samp(); idle(6); end
    idle(10);

    // R8 held trigger: M=1, N=5, samples 4 cycles apart
    cur_tag = "R8";
    wr(2'd1, 8'd0);
    for (int i = 0; i < 4; i++) begin samp(); idle(6); end
    wr(2'd0, 8'd0); wr(2'd2, 8'd4); do_sync();
    for (int i = 0; i < 3; i++) begin samp(); idle(2); end
    idle(30);

    chk(q.size() == 0, "R8", "taps outstanding", q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule